// File: doc/BRIEF.md
# Nine-Track Cross-Parity Block Codec

This block protects blocks of 8-bit characters bound for a nine-track recording medium with two crossed odd-parity checks. It has two independent paths.

The write path takes a byte stream and passes each byte on as a 9-bit frame. Bits 7:0 of the frame carry the byte and bit 8 carries a generated parity bit. After the byte marked last, it emits one extra frame, the check character, which closes a parity check along every track.

The read path collects the frames of one block and the trailing check character. It then tests parity in both directions. A character with even parity marks a failing column, and a track with even parity along the block marks a failing row. From the crossing of the two it repairs one flipped bit, or one dead track. It then replays the data bytes with a 2-bit status code.

Both stream interfaces are valid/ready. A sender must hold valid and its payload steady until ready is seen high at a clock edge. A transfer occurs on every edge where both are high.
- On the write path, `wr_in_ready` follows `wr_out_ready` combinationally. It is forced low while the check character is waiting to be taken.
- On the read path, `rd_in_ready` is high only while frames are being collected.
- `rd_out_valid` rises only after the check character has been accepted and one decide cycle has passed. While `rd_out_ready` is low, the data, status and last outputs are held.

Top module: `tape_xparity`

## Requirements
- R1: Every write-side data frame carries the input byte in bits 7:0. Its bit 8 makes the count of ones in the 9-bit frame odd.
- R2: After the byte flagged `wr_in_last`, exactly one further frame is emitted with `wr_out_chk` high. For each of the 9 bit positions, the XOR of all data frames of the block and the check frame equals 1.
- R3: `wr_in_ready` is low whenever `wr_out_ready` is low. It is also low while the check frame is being offered.
- R4: The read input accepts frames only while collecting. No read output is offered before the check frame (`rd_in_chk` high) is accepted. `rd_in_ready` stays low from then until the last output beat is taken, and is high again in the following cycle.
- R5: A block with no parity failure is replayed unchanged with status 00.
- R6: If exactly one data bit of one character is flipped, that bit is restored and the status is 01.
- R7: If only the bit-8 parity bit of one character, or only one bit of the check frame, is wrong, the data is replayed unchanged with status 01.
- R8: If exactly one track fails and two or more characters fail, that track's bit is inverted in every failing character and the status is 10.
- R9: The status is 11 and the data is replayed exactly as received in these cases: two or more tracks fail, characters fail while no track fails, or more than BLK_MAX data frames arrive (only the first BLK_MAX are kept and replayed).
- R10: Each replayed block has one beat per stored character. `rd_out_last` is high only on the final beat, and the status stays constant across the block. While `rd_out_valid` is high and `rd_out_ready` is low, data, status and last hold their values.
- R11: A check frame with no data frames before it yields a single beat with data 00, `rd_out_last` high and status 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_in_valid | input | 1 | Write byte offered |
| wr_in_ready | output | 1 | Write byte accepted |
| wr_in_data | input | 8 | Write byte |
| wr_in_last | input | 1 | Byte ends the block |
| wr_out_valid | output | 1 | Frame offered to the medium |
| wr_out_ready | input | 1 | Medium takes the frame |
| wr_out_frame | output | 9 | Frame: data in 7:0, parity in 8 |
| wr_out_chk | output | 1 | Frame is the check character |
| rd_in_valid | input | 1 | Frame from the medium offered |
| rd_in_ready | output | 1 | Frame accepted |
| rd_in_frame | input | 9 | Frame as read |
| rd_in_chk | input | 1 | Frame is the check character |
| rd_out_valid | output | 1 | Repaired byte offered |
| rd_out_ready | input | 1 | Consumer takes the byte |
| rd_out_data | output | 8 | Repaired byte |
| rd_out_last | output | 1 | Final byte of the block |
| rd_out_status | output | 2 | 00 clean, 01 single, 10 dead track, 11 uncorrectable |

## Verification
The bench injects a flip at the first and last character positions. A corrector with an off-by-one column pointer would repair the wrong byte. It flips only a parity bit or only a check bit; a design that used the bit-8 row as a data index would corrupt a byte. Two flips inside one character, and two flips in one track, each produce a failure pattern that a naive corrector would "fix" wrongly, and the bench expects status 11 with the data untouched. The empty and overflowing blocks catch a replay counter that underflows or runs past storage. Toggled ready on both outputs exposes a check frame that slips past a stall, or data that changes while held.

// File: rtl/tape_xparity_pkg.sv
package tape_xparity_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN  = 2'b00,
    ST_SINGLE = 2'b01,
    ST_DEAD   = 2'b10,
    ST_UNCORR = 2'b11
  } xp_status_e;

  typedef enum logic [1:0] {
    RX_COLLECT,
    RX_DECIDE,
    RX_REPLAY
  } rx_state_e;
endpackage

// File: rtl/tpx_encoder.sv
module tpx_encoder #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W:0]   out_frame,
  output logic              out_chk
);
  logic [DATA_W:0] acc;
  logic [DATA_W:0] dframe;
  logic            pend;

  // odd vertical parity: parity bit set when data holds an even count of ones
  assign dframe    = {~^in_data, in_data};
  assign out_valid = pend | in_valid;
  assign out_chk   = pend;
  assign in_ready  = out_ready & ~pend;
  assign out_frame = pend ? ~acc : dframe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      pend <= 1'b0;
    end else if (pend) begin
      if (out_ready) begin
        pend <= 1'b0;
        acc  <= '0;
      end
    end else if (in_valid && in_ready) begin
      acc <= acc ^ dframe;
      if (in_last) pend <= 1'b1;
    end
  end
endmodule

// File: rtl/tpx_classify.sv
module tpx_classify
  import tape_xparity_pkg::*;
#(
  parameter int TRACKS  = 9,
  parameter int BLK_MAX = 16,
  localparam int CW     = $clog2(BLK_MAX + 1)
) (
  input  logic [TRACKS-1:0]  row_fail,
  input  logic [BLK_MAX-1:0] col_fail,
  input  logic [CW-1:0]      cnt,
  input  logic               ovf,
  output xp_status_e         status
);
  int nrow;
  int ncol;

  always_comb begin
    nrow = 0;
    ncol = 0;
    for (int t = 0; t < TRACKS; t++)  nrow = nrow + int'(row_fail[t]);
    for (int c = 0; c < BLK_MAX; c++) ncol = ncol + int'(col_fail[c]);
    if (cnt == '0 || ovf)             status = ST_UNCORR;
    else if (nrow == 0 && ncol == 0)  status = ST_CLEAN;
    else if (nrow == 1 && ncol <= 1)  status = ST_SINGLE;
    else if (nrow == 1)               status = ST_DEAD;
    else                              status = ST_UNCORR;
  end
endmodule

// File: rtl/tpx_decoder.sv
module tpx_decoder
  import tape_xparity_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int BLK_MAX = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W:0]   in_frame,
  input  logic              in_chk,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic [1:0]        out_status
);
  localparam int TRACKS = DATA_W + 1;
  localparam int CW     = $clog2(BLK_MAX + 1);
  localparam int AW     = $clog2(BLK_MAX);

  rx_state_e          st;
  logic [DATA_W-1:0]  mem [BLK_MAX];
  logic [BLK_MAX-1:0] col_fail;
  logic [TRACKS-1:0]  acc;
  logic [TRACKS-1:0]  row_fail;
  logic [CW-1:0]      cnt;
  logic [AW-1:0]      ptr;
  logic               ovf;
  logic               fix_q;
  xp_status_e         stat_q;
  xp_status_e         stat_c;
  logic               take_data, take_chk, beat, empty, room;

  assign in_ready  = (st == RX_COLLECT);
  assign take_data = in_valid && in_ready && !in_chk;
  assign take_chk  = in_valid && in_ready && in_chk;
  assign empty     = (cnt == '0);
  assign room      = (cnt < CW'(BLK_MAX));
  assign out_valid = (st == RX_REPLAY);
  assign beat      = out_valid && out_ready;
  assign out_last  = empty || (CW'(ptr) == cnt - CW'(1));
  assign out_status = stat_q;
  assign out_data  = empty ? '0 :
    mem[ptr] ^ ({DATA_W{fix_q & col_fail[ptr]}} & row_fail[DATA_W-1:0]);

  tpx_classify #(.TRACKS(TRACKS), .BLK_MAX(BLK_MAX)) u_cls (
    .row_fail (row_fail),
    .col_fail (col_fail),
    .cnt      (cnt),
    .ovf      (ovf),
    .status   (stat_c)
  );

  always_ff @(posedge clk) begin
    if (take_data && room) mem[AW'(cnt)] <= in_frame[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= RX_COLLECT;
      col_fail <= '0;
      acc      <= '0;
      row_fail <= '0;
      cnt      <= '0;
      ptr      <= '0;
      ovf      <= 1'b0;
      fix_q    <= 1'b0;
      stat_q   <= ST_CLEAN;
    end else begin
      case (st)
        RX_COLLECT: begin
          if (take_chk) begin
            // a track passes when its ones count, check bit included, is odd
            row_fail <= ~(acc ^ in_frame);
            st       <= RX_DECIDE;
          end else if (take_data) begin
            acc <= acc ^ in_frame;
            if (room) begin
              col_fail[AW'(cnt)] <= ~^in_frame;
              cnt                <= cnt + CW'(1);
            end else begin
              ovf <= 1'b1;
            end
          end
        end
        RX_DECIDE: begin
          stat_q <= stat_c;
          fix_q  <= (stat_c == ST_SINGLE) || (stat_c == ST_DEAD);
          ptr    <= '0;
          st     <= RX_REPLAY;
        end
        default: begin
          if (beat) begin
            if (out_last) begin
              st       <= RX_COLLECT;
              cnt      <= '0;
              acc      <= '0;
              col_fail <= '0;
              ovf      <= 1'b0;
            end else begin
              ptr <= ptr + AW'(1);
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/tape_xparity.sv
module tape_xparity #(
  parameter int DATA_W  = 8,
  parameter int BLK_MAX = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_in_valid,
  output logic              wr_in_ready,
  input  logic [DATA_W-1:0] wr_in_data,
  input  logic              wr_in_last,
  output logic              wr_out_valid,
  input  logic              wr_out_ready,
  output logic [DATA_W:0]   wr_out_frame,
  output logic              wr_out_chk,
  input  logic              rd_in_valid,
  output logic              rd_in_ready,
  input  logic [DATA_W:0]   rd_in_frame,
  input  logic              rd_in_chk,
  output logic              rd_out_valid,
  input  logic              rd_out_ready,
  output logic [DATA_W-1:0] rd_out_data,
  output logic              rd_out_last,
  output logic [1:0]        rd_out_status
);
  tpx_encoder #(.DATA_W(DATA_W)) u_enc (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (wr_in_valid),
    .in_ready  (wr_in_ready),
    .in_data   (wr_in_data),
    .in_last   (wr_in_last),
    .out_valid (wr_out_valid),
    .out_ready (wr_out_ready),
    .out_frame (wr_out_frame),
    .out_chk   (wr_out_chk)
  );

  tpx_decoder #(.DATA_W(DATA_W), .BLK_MAX(BLK_MAX)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (rd_in_valid),
    .in_ready   (rd_in_ready),
    .in_frame   (rd_in_frame),
    .in_chk     (rd_in_chk),
    .out_valid  (rd_out_valid),
    .out_ready  (rd_out_ready),
    .out_data   (rd_out_data),
    .out_last   (rd_out_last),
    .out_status (rd_out_status)
  );
endmodule

// File: rtl/tape_xparity_chk.sv
module tape_xparity_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_in_ready,
  input logic              wr_out_valid,
  input logic              wr_out_ready,
  input logic [DATA_W:0]   wr_out_frame,
  input logic              wr_out_chk,
  input logic              rd_in_ready,
  input logic              rd_out_valid,
  input logic              rd_out_ready,
  input logic [DATA_W-1:0] rd_out_data,
  input logic              rd_out_last,
  input logic [1:0]        rd_out_status
);
  assert_frame_odd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_out_valid && !wr_out_chk) |-> (^wr_out_frame));

  assert_chk_blocks_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_out_chk || !wr_out_ready) |-> !wr_in_ready);

  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_in_ready && rd_out_valid));

  assert_reopen_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_out_valid && rd_out_ready && rd_out_last) |=> rd_in_ready);

  assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_out_valid && !rd_out_ready) |=>
      (rd_out_valid && $stable(rd_out_data) && $stable(rd_out_status) && $stable(rd_out_last)));

  assert_status_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_out_valid && rd_out_ready && !rd_out_last) |=> (rd_out_valid && $stable(rd_out_status)));
endmodule

bind tape_xparity tape_xparity_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_in_ready   (wr_in_ready),
  .wr_out_valid  (wr_out_valid),
  .wr_out_ready  (wr_out_ready),
  .wr_out_frame  (wr_out_frame),
  .wr_out_chk    (wr_out_chk),
  .rd_in_ready   (rd_in_ready),
  .rd_out_valid  (rd_out_valid),
  .rd_out_ready  (rd_out_ready),
  .rd_out_data   (rd_out_data),
  .rd_out_last   (rd_out_last),
  .rd_out_status (rd_out_status)
);

// File: tb/tape_xparity_tb.sv
`timescale 1ns/1ps
module tape_xparity_tb;
  localparam int BLK = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_in_valid = 1'b0, wr_in_last = 1'b0, wr_out_ready = 1'b0;
  logic [7:0] wr_in_data = '0;
  logic       wr_in_ready, wr_out_valid, wr_out_chk;
  logic [8:0] wr_out_frame;
  logic       rd_in_valid = 1'b0, rd_in_chk = 1'b0, rd_out_ready = 1'b0;
  logic [8:0] rd_in_frame = '0;
  logic       rd_in_ready, rd_out_valid, rd_out_last;
  logic [7:0] rd_out_data;
  logic [1:0] rd_out_status;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  logic [7:0] b   [0:79];
  logic [8:0] fr  [0:79];
  logic [7:0] ex  [0:79];
  logic [8:0] chkc;

  always #2.5 clk = ~clk;

  tape_xparity #(.DATA_W(8), .BLK_MAX(BLK)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_in_valid(wr_in_valid), .wr_in_ready(wr_in_ready), .wr_in_data(wr_in_data),
    .wr_in_last(wr_in_last), .wr_out_valid(wr_out_valid), .wr_out_ready(wr_out_ready),
    .wr_out_frame(wr_out_frame), .wr_out_chk(wr_out_chk),
    .rd_in_valid(rd_in_valid), .rd_in_ready(rd_in_ready), .rd_in_frame(rd_in_frame),
    .rd_in_chk(rd_in_chk), .rd_out_valid(rd_out_valid), .rd_out_ready(rd_out_ready),
    .rd_out_data(rd_out_data), .rd_out_last(rd_out_last), .rd_out_status(rd_out_status)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic build(input int len, input int seed);
    logic [8:0] x = '0;
    for (int k = 0; k < len; k++) begin
      b[k]  = 8'((k * 29) + (seed * 7) + 3);
      fr[k] = {~^b[k], b[k]};
      ex[k] = b[k];
      x     = x ^ fr[k];
    end
    chkc = ~x;
  endtask

  task automatic t_reset();
    check(rd_in_ready == 1'b1, "R4", "collect after reset", 32'(rd_in_ready), 1);
    check(rd_out_valid == 1'b0, "R4", "no output after reset", 32'(rd_out_valid), 0);
    check(wr_out_valid == 1'b0, "R2", "no frame after reset", 32'(wr_out_valid), 0);
  endtask

  task automatic t_encode(input int len, input int seed);
    logic [8:0] got [0:79];
    logic [8:0] cf = '0;
    logic [8:0] x = '0;
    int i = 0, nf = 0, cyc = 0;
    bit done = 0, stall_seen = 0;
    build(len, seed);
    while (!done && cyc < 2000) begin
      @(negedge clk);
      wr_in_valid  = 1'b1;
      wr_in_data   = (i < len) ? b[i] : 8'h5A;
      wr_in_last   = (i == len - 1);
      wr_out_ready = (cyc % 3) != 2;
      cyc++;
      #1;
      if (!wr_out_ready)
        check(!wr_in_ready, "R3", "input ready while output stalled", 32'(wr_in_ready), 0);
      if (wr_out_valid && wr_out_chk) begin
        check(!wr_in_ready, "R3", "input ready during check frame", 32'(wr_in_ready), 0);
        stall_seen = 1;
      end
      if (wr_out_valid && wr_out_ready) begin
        if (wr_out_chk) begin cf = wr_out_frame; done = 1; end
        else begin got[nf] = wr_out_frame; nf++; end
      end
      if (wr_in_valid && wr_in_ready && i < len) i++;
    end
    @(negedge clk);
    wr_in_valid = 1'b0; wr_in_last = 1'b0; wr_out_ready = 1'b0;
    check(done, "R2", "check frame emitted", 32'(done), 1);
    check(nf == len, "R2", "data frame count", 32'(nf), 32'(len));
    check(stall_seen, "R3", "check frame observed with stall", 32'(stall_seen), 1);
    for (int k = 0; k < len && k < nf; k++) begin
      check(got[k] == {~^b[k], b[k]}, "R1", "frame content", 32'(got[k]), 32'({~^b[k], b[k]}));
      x = x ^ got[k];
    end
    check((x ^ cf) == 9'h1FF, "R2", "per-track odd parity", 32'(x ^ cf), 32'h1FF);
  endtask

  task automatic send_frame(input logic [8:0] f, input bit c);
    rd_in_valid = 1'b1; rd_in_frame = f; rd_in_chk = c;
    while (!rd_in_ready) @(negedge clk);
    @(negedge clk);
    rd_in_valid = 1'b0; rd_in_chk = 1'b0;
  endtask

  task automatic run_rd(input int len, input logic [1:0] est, input string req);
    int nb, k = 0, cyc = 0;
    logic [1:0] st0 = '0;
    nb = (len == 0) ? 1 : ((len > BLK) ? BLK : len);
    for (int j = 0; j < len; j++) send_frame(fr[j], 1'b0);
    check(!rd_out_valid, "R4", "output before check frame", 32'(rd_out_valid), 0);
    send_frame(chkc, 1'b1);
    check(!rd_in_ready, "R4", "input closed after check frame", 32'(rd_in_ready), 0);
    while (k < nb && cyc < 1000) begin
      rd_out_ready = (cyc % 4) != 1;
      cyc++;
      if (rd_out_valid && rd_out_ready) begin
        if (k == 0) st0 = rd_out_status;
        check(rd_out_data == ex[k], req, "replayed data", 32'(rd_out_data), 32'(ex[k]));
        check(rd_out_status == est, req, "status", 32'(rd_out_status), 32'(est));
        check(rd_out_status == st0, "R10", "status constant", 32'(rd_out_status), 32'(st0));
        check(rd_out_last == (k == nb - 1), "R10", "last flag", 32'(rd_out_last), 32'(k == nb - 1));
        k++;
      end
      @(negedge clk);
    end
    rd_out_ready = 1'b0;
    check(k == nb, "R10", "beat count", 32'(k), 32'(nb));
    check(rd_in_ready, "R4", "input reopened", 32'(rd_in_ready), 1);
  endtask

  task automatic t_clean();
    build(BLK, 1); run_rd(BLK, 2'b00, "R5");
  endtask

  task automatic t_single_first();
    build(BLK, 2); fr[0] = fr[0] ^ 9'h008; run_rd(BLK, 2'b01, "R6");
  endtask

  task automatic t_single_last();
    build(BLK, 3); fr[BLK-1] = fr[BLK-1] ^ 9'h080; run_rd(BLK, 2'b01, "R6");
  endtask

  task automatic t_short_single();
    build(1, 4); fr[0] = fr[0] ^ 9'h001; run_rd(1, 2'b01, "R6");
  endtask

  task automatic t_parity_bit();
    build(BLK, 5); fr[2] = fr[2] ^ 9'h100; run_rd(BLK, 2'b01, "R7");
  endtask

  task automatic t_check_bit();
    build(BLK, 6); chkc = chkc ^ 9'h010; run_rd(BLK, 2'b01, "R7");
  endtask

  task automatic t_dead_track();
    build(BLK, 7);
    fr[1] = fr[1] ^ 9'h040; fr[4] = fr[4] ^ 9'h040; fr[9] = fr[9] ^ 9'h040;
    run_rd(BLK, 2'b10, "R8");
  endtask

  task automatic t_double_in_char();
    build(BLK, 8); fr[3] = fr[3] ^ 9'h003; ex[3] = fr[3][7:0];
    run_rd(BLK, 2'b11, "R9");
  endtask

  task automatic t_double_in_track();
    build(BLK, 9);
    fr[1] = fr[1] ^ 9'h004; fr[2] = fr[2] ^ 9'h004;
    ex[1] = fr[1][7:0]; ex[2] = fr[2][7:0];
    run_rd(BLK, 2'b11, "R9");
  endtask

  task automatic t_overflow();
    build(BLK + 1, 10); run_rd(BLK + 1, 2'b11, "R9");
  endtask

  task automatic t_empty();
    chkc = 9'h1FF; ex[0] = 8'h00; run_rd(0, 2'b11, "R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_encode(BLK, 0);
    t_encode(1, 11);
    t_clean();
    t_single_first();
    t_single_last();
    t_short_single();
    t_parity_bit();
    t_check_bit();
    t_dead_track();
    t_double_in_char();
    t_double_in_track();
    t_overflow();
    t_empty();
    t_clean();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule